// File: doc/BRIEF.md
# SDRAM Byte-Mask and Read-Latency Data Pipeline

This block sits on the controller side of an SDRAM data bus that carries byte masks. It turns column commands into per-beat timing. A read command starts a burst of read beats. Each beat comes back on the bus a programmable number of cycles later, and the block raises a capture strobe at that point. A write command starts a burst of write beats. During each write beat the block enables the data output and drives the byte masks in the same cycle.

Mask requests apply to the two directions differently. A mask asserted during a write blocks that cycle's bytes immediately. A mask asserted for a read blanks the bytes that return two cycles later, and a returning beat whose lanes are all blanked is reported as invalid. A burst-stop or precharge command ends the issue of further beats, but beats already on their way back still arrive. The block reports how many of those beats are still outstanding.

The burst sequencer has three states. ST_IDLE issues nothing. ST_READ issues one read beat per cycle. ST_WRITE issues one write beat per cycle. The transitions are as follows. A read or write command in any state (start/restart) moves to ST_READ or ST_WRITE. A single-beat burst stays in, or returns to, ST_IDLE. A burst-stop or precharge (abort) returns to ST_IDLE. When the last counted beat is issued (done), the state returns to ST_IDLE. A full-page burst never reaches done.

Top module: `sdram_dq_pipe`

## Requirements
- R1: After reset, with a NOP command and no mask requested, rd_valid, dq_oe, rd_byte_en, wr_byte_en and rd_pending are all zero.
- R2: Commands are encoded on cmd as follows: 0 NOP, 1 READ, 2 WRITE, 3 burst stop, 4 precharge. Codes 5 to 7 act as NOP.
- R3: The burst length code is bl_code. Codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, code 7 gives a full-page burst that continues until it is interrupted, and codes 4 to 6 give 1 beat. A burst issues one beat per cycle, and the command cycle issues the first beat.
- R4: A read beat issued in cycle c returns in cycle c+2 when cas3=0 and in cycle c+3 when cas3=1.
- R5: For a returning beat, rd_byte_en is the inverse of mask_req sampled two cycles earlier. It is zero when no beat returns.
- R6: A returning beat with all byte lanes masked leaves rd_valid low. Any other returning beat raises rd_valid.
- R7: During a write beat, dq_oe is high and wr_byte_en is the inverse of mask_req in the same cycle. In all other cycles, both are zero.
- R8: dq_oe and wr_byte_en are forced to zero in any cycle where a read beat returns, even during a write burst.
- R9: A burst stop or precharge issues no beat in its own cycle or afterwards, while beats in flight still return. After a full-rate read burst is cut, this gives 2 more beats at cas3=1 and 1 at cas3=0.
- R10: rd_pending equals the number of read beats issued that have not yet returned. Its maximum is 2 at cas3=1 and 1 at cas3=0.
- R11: A READ or WRITE arriving during a burst abandons the rest of that burst and starts a new burst with the current bl_code.
- R12: dqm equals mask_req in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cas3 | input | 1 | 1 selects read latency 3, 0 selects latency 2 |
| bl_code | input | 3 | Burst length code, sampled with READ/WRITE |
| cmd | input | 3 | Command code for this cycle |
| mask_req | input | NB | Per-byte mask request for this cycle |
| dqm | output | NB | Byte mask lines to the memory |
| dq_oe | output | 1 | Write data output enable |
| wr_byte_en | output | NB | Bytes actually written this cycle |
| rd_valid | output | 1 | A read beat with at least one live byte is on the bus |
| rd_byte_en | output | NB | Live bytes of the returning read beat |
| rd_pending | output | 2 | Read beats issued and not yet returned |

## Verification
The bench cuts read bursts with both a burst stop and a precharge, at each latency, and counts the beats that still arrive. A design that cleared the in-flight beats would return none, and one that kept issuing would return too many. Masks are placed so that they must line up two cycles later on reads but in the same cycle on writes, including a fully masked read beat. Swapping the two latencies, or reporting a blanked beat as valid, shows up as a miscompare. A write is started right behind a read so that its beats collide with returning data, which catches an output enable that fights the bus. Full-page, reserved-length and restart-in-mid-burst cases cover the burst counter.

// File: rtl/sdram_dp_pkg.sv
package sdram_dp_pkg;
    localparam int CL_MAX      = 3;
    localparam int RD_MASK_LAT = 2;
    localparam int PEND_W      = $clog2(CL_MAX);

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_BSTOP = 3'd3,
        CMD_PRECH = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/sdp_burst_seq.sv
module sdp_burst_seq
    import sdram_dp_pkg::*;
#(
    parameter int MAX_BURST = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cmd,
    input  logic [2:0] bl_code,
    output logic       rd_issue,
    output logic       wr_issue
);
    localparam int CW = $clog2(MAX_BURST + 1);

    seq_state_e    st, st_n;
    logic [CW-1:0] rem, rem_n;
    logic          full, full_n;
    logic [CW-1:0] beats;
    logic          is_col, is_abort;

    assign is_col   = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    assign is_abort = (cmd == CMD_BSTOP) || (cmd == CMD_PRECH);

    always_comb begin
        case (bl_code)
            3'd1:    beats = CW'(2);
            3'd2:    beats = CW'(4);
            3'd3:    beats = CW'(8);
            default: beats = CW'(1);
        endcase
    end

    // next state
    always_comb begin
        st_n   = st;
        rem_n  = rem;
        full_n = full;
        if (is_col) begin
            if (bl_code == 3'd7) begin
                st_n   = (cmd == CMD_READ) ? ST_READ : ST_WRITE;
                full_n = 1'b1;
                rem_n  = '0;
            end else if (beats == CW'(1)) begin
                st_n   = ST_IDLE;
                full_n = 1'b0;
                rem_n  = '0;
            end else begin
                st_n   = (cmd == CMD_READ) ? ST_READ : ST_WRITE;
                full_n = 1'b0;
                rem_n  = beats - CW'(1);
            end
        end else if (is_abort) begin
            st_n   = ST_IDLE;
            full_n = 1'b0;
            rem_n  = '0;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_READ, ST_WRITE: begin
                    if (!full) begin
                        rem_n = rem - CW'(1);
                        if (rem == CW'(1)) st_n = ST_IDLE;
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            rem  <= '0;
            full <= 1'b0;
        end else begin
            st   <= st_n;
            rem  <= rem_n;
            full <= full_n;
        end
    end

    // outputs
    always_comb begin
        rd_issue = 1'b0;
        wr_issue = 1'b0;
        if (cmd == CMD_READ) begin
            rd_issue = 1'b1;
        end else if (cmd == CMD_WRITE) begin
            wr_issue = 1'b1;
        end else if (!is_abort) begin
            unique case (st)
                ST_IDLE:  ;
                ST_READ:  rd_issue = 1'b1;
                ST_WRITE: wr_issue = 1'b1;
                default:  ;
            endcase
        end
    end

    // R9: an abort leaves nothing issuing next cycle unless a new column command arrives
    a_r9_abort_silences: assert property (@(posedge clk) disable iff (!rst_n)
        is_abort |=> (is_col || (!rd_issue && !wr_issue)));

    a_r3_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_issue && wr_issue));
endmodule

// File: rtl/sdp_rd_return.sv
module sdp_rd_return
    import sdram_dp_pkg::*;
#(
    parameter int NB = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cas3,
    input  logic              rd_issue,
    input  logic [NB-1:0]     mask_req,
    output logic              beat_arrive,
    output logic              rd_valid,
    output logic [NB-1:0]     rd_byte_en,
    output logic [PEND_W-1:0] rd_pending
);
    logic [CL_MAX-1:0] sr;
    logic [NB-1:0]     mpipe [RD_MASK_LAT];
    int                tap;

    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[CL_MAX-2:0], rd_issue};
    end

    for (genvar g = 0; g < RD_MASK_LAT; g++) begin : g_mask
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) mpipe[0] <= '0;
                else        mpipe[0] <= mask_req;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (!rst_n) mpipe[g] <= '0;
                else        mpipe[g] <= mpipe[g-1];
            end
        end
    end

    assign tap         = cas3 ? CL_MAX - 1 : CL_MAX - 2;
    assign beat_arrive = sr[tap];
    assign rd_valid    = beat_arrive && !(&mpipe[RD_MASK_LAT-1]);
    assign rd_byte_en  = beat_arrive ? ~mpipe[RD_MASK_LAT-1] : '0;

    always_comb begin
        rd_pending = '0;
        for (int i = 0; i < CL_MAX - 1; i++) begin
            if (i < tap) rd_pending = rd_pending + PEND_W'(sr[i]);
        end
    end

    // R6: an all-masked returning beat is never reported valid
    a_r6_full_mask_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_arrive && ($past(mask_req, 2) == {NB{1'b1}})) |-> !rd_valid);

    a_r10_pending_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pending <= (cas3 ? PEND_W'(2) : PEND_W'(1)));
endmodule

// File: rtl/sdram_dq_pipe.sv
module sdram_dq_pipe
    import sdram_dp_pkg::*;
#(
    parameter int NB        = 9,
    parameter int MAX_BURST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cas3,
    input  logic [2:0]        bl_code,
    input  logic [2:0]        cmd,
    input  logic [NB-1:0]     mask_req,
    output logic [NB-1:0]     dqm,
    output logic              dq_oe,
    output logic [NB-1:0]     wr_byte_en,
    output logic              rd_valid,
    output logic [NB-1:0]     rd_byte_en,
    output logic [PEND_W-1:0] rd_pending
);
    logic rd_issue, wr_issue, beat_arrive;

    sdp_burst_seq #(.MAX_BURST(MAX_BURST)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .bl_code  (bl_code),
        .rd_issue (rd_issue),
        .wr_issue (wr_issue)
    );

    sdp_rd_return #(.NB(NB)) u_ret (
        .clk         (clk),
        .rst_n       (rst_n),
        .cas3        (cas3),
        .rd_issue    (rd_issue),
        .mask_req    (mask_req),
        .beat_arrive (beat_arrive),
        .rd_valid    (rd_valid),
        .rd_byte_en  (rd_byte_en),
        .rd_pending  (rd_pending)
    );

    assign dqm        = mask_req;
    assign dq_oe      = wr_issue && !beat_arrive;
    assign wr_byte_en = dq_oe ? ~mask_req : '0;

    // R8: the write driver never meets returning read data
    a_r8_no_oe_on_return: assert property (@(posedge clk) disable iff (!rst_n)
        beat_arrive |-> (!dq_oe && wr_byte_en == '0));

    // R4: at latency 3 a returning beat was issued three cycles before
    a_r4_cl3_tap: assert property (@(posedge clk) disable iff (!rst_n)
        (cas3 && $past(cas3, 3) && beat_arrive) |-> $past(rd_issue, 3));
endmodule

// File: tb/sdram_dq_pipe_test.sv
module sdram_dq_pipe_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cas3 = 1'b1;
    logic [2:0]    bl_code = 3'd0;
    logic [2:0]    cmd = 3'd0;
    logic [NB-1:0] mask_req = '0;
    logic [NB-1:0] dqm, wr_byte_en, rd_byte_en;
    logic          dq_oe, rd_valid;
    logic [1:0]    rd_pending;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    int            m_mode = 0;   // 0 idle, 1 read, 2 write
    int            m_rem = 0;
    bit            m_full = 0;
    bit [3:1]      m_hist = '0;
    logic [NB-1:0] m_mk1 = '0, m_mk2 = '0;
    bit            last_rv;

    sdram_dq_pipe #(.NB(NB)) uut (
        .clk(clk), .rst_n(rst_n), .cas3(cas3), .bl_code(bl_code), .cmd(cmd),
        .mask_req(mask_req), .dqm(dqm), .dq_oe(dq_oe), .wr_byte_en(wr_byte_en),
        .rd_valid(rd_valid), .rd_byte_en(rd_byte_en), .rd_pending(rd_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int blen(input logic [2:0] c);
        case (c)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            default: return 1;
        endcase
    endfunction

    task automatic cyc(input logic [2:0] c, input logic [NB-1:0] m);
        bit rdi, wri, arr, e_rv, e_oe;
        int nmode, nrem;
        bit nfull;
        logic [NB-1:0] e_rbe, e_wbe;
        @(negedge clk);
        cmd = c;
        mask_req = m;
        #1;
        rdi = 0; wri = 0;
        nmode = m_mode; nrem = m_rem; nfull = m_full;
        if (c == 3'd1 || c == 3'd2) begin
            if (c == 3'd1) rdi = 1; else wri = 1;
            if (bl_code == 3'd7) begin
                nmode = (c == 3'd1) ? 1 : 2; nfull = 1; nrem = 0;
            end else if (blen(bl_code) == 1) begin
                nmode = 0; nfull = 0; nrem = 0;
            end else begin
                nmode = (c == 3'd1) ? 1 : 2; nfull = 0; nrem = blen(bl_code) - 1;
            end
        end else if (c == 3'd3 || c == 3'd4) begin
            nmode = 0; nfull = 0; nrem = 0;
        end else if (m_mode != 0) begin
            if (m_mode == 1) rdi = 1; else wri = 1;
            if (!m_full) begin
                nrem = m_rem - 1;
                if (m_rem == 1) nmode = 0;
            end
        end
        arr   = cas3 ? m_hist[3] : m_hist[2];
        e_rv  = arr && (m_mk2 != {NB{1'b1}});
        e_rbe = arr ? ~m_mk2 : '0;
        e_oe  = wri && !arr;
        e_wbe = e_oe ? ~m : '0;
        chk("R4/R6", "rd_valid", rd_valid, e_rv);
        chk("R5", "rd_byte_en", rd_byte_en, e_rbe);
        chk("R7/R8", "dq_oe", dq_oe, e_oe);
        chk("R7/R8", "wr_byte_en", wr_byte_en, e_wbe);
        chk("R10", "rd_pending", rd_pending,
            cas3 ? (int'(m_hist[1]) + int'(m_hist[2])) : int'(m_hist[1]));
        chk("R12", "dqm", dqm, m);
        last_rv = rd_valid;
        @(posedge clk);
        m_hist = {m_hist[2:1], rdi};
        m_mk2 = m_mk1; m_mk1 = m;
        m_mode = nmode; m_rem = nrem; m_full = nfull;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(3'd0, '0);
    endtask

    task automatic cut_count(input bit cl3, input logic [2:0] stopcmd, input int exp_tail);
        int tail;
        cas3 = cl3;
        bl_code = 3'd3;
        cyc(3'd1, '0);
        cyc(3'd0, '0);
        cyc(3'd0, '0);
        cyc(3'd0, '0);
        cyc(stopcmd, '0);
        tail = 0;
        for (int i = 0; i < 5; i++) begin
            cyc(3'd0, '0);
            tail += int'(last_rv);
        end
        chk("R9", "beats after cut", tail, exp_tail);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "rd_valid", rd_valid, 0);
        chk("R1", "dq_oe", dq_oe, 0);
        chk("R1", "rd_pending", rd_pending, 0);
        chk("R1", "byte enables", int'(rd_byte_en | wr_byte_en), 0);

        // R3/R4: latency 3, burst of 4
        cas3 = 1; bl_code = 3'd2;
        cyc(3'd1, '0); idle(6);
        // R4/R5/R6: latency 2, burst of 8, masks including a fully masked beat
        cas3 = 0; bl_code = 3'd3;
        cyc(3'd1, 9'h001);
        cyc(3'd0, 9'h1FF);
        cyc(3'd0, 9'h0F0);
        cyc(3'd0, 9'h1FF);
        cyc(3'd0, 9'h100);
        idle(6);
        // R7: write burst with same-cycle masks
        bl_code = 3'd2;
        cyc(3'd2, 9'h003);
        cyc(3'd0, 9'h000);
        cyc(3'd0, 9'h1FF);
        cyc(3'd0, 9'h0AA);
        idle(2);
        // R9: cuts at both latencies, stop and precharge
        cut_count(1'b1, 3'd4, 2);
        idle(2);
        cut_count(1'b0, 3'd3, 1);
        idle(2);
        cut_count(1'b1, 3'd3, 2);
        idle(2);
        cut_count(1'b0, 3'd4, 1);
        idle(2);
        // R3 full page read until stopped
        cas3 = 0; bl_code = 3'd7;
        cyc(3'd1, '0); idle(20); cyc(3'd3, '0); idle(4);
        // R3 reserved length codes and R2 reserved command codes act as NOP
        cas3 = 1; bl_code = 3'd5;
        cyc(3'd1, '0); cyc(3'd6, '0); cyc(3'd7, '0); cyc(3'd5, '0); idle(3);
        // R8: write right behind a read collides with returning data
        bl_code = 3'd1;
        cyc(3'd1, '0);
        bl_code = 3'd3;
        cyc(3'd2, 9'h011);
        idle(9);
        // R11: restart mid burst, read->read and write->read
        bl_code = 3'd3;
        cyc(3'd1, '0); cyc(3'd0, '0);
        bl_code = 3'd1;
        cyc(3'd1, 9'h002); idle(6);
        bl_code = 3'd2;
        cyc(3'd2, '0); cyc(3'd0, '0);
        cyc(3'd1, '0); idle(6);
        // full page write then precharge
        bl_code = 3'd7;
        cyc(3'd2, 9'h055); idle(10); cyc(3'd4, '0); idle(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule